// File: doc/BRIEF.md
# VID Reference Ramp and Power-Good Sequencer

This block feeds the reference DAC of a step-down regulator. It takes a 7-bit voltage code in which each code is 10 mV above the previous one. Code 0 is 0.72 V and code 76 is 1.48 V. The block does not jump to a new code. It moves its DAC code toward the accepted target one code at a time. The wait between steps is a whole number of microseconds, from 1 to 8. Rising and falling ramps each have their own wait setting. A prescaler divides the system clock down to a 1 µs tick, and all timing in the block is counted in these ticks.

The block also drives the power-good flag. Three comparator levels from the analog side come in as inputs:
- below 87.5 % of nominal;
- at or above 90 %;
- above 92.5 %.

Power-good stays low until soft-start is done. It is first released at the 90 % level. It drops after an under-voltage condition has lasted for a selectable delay. Once it has dropped, it returns only when the output is above the 92.5 % level.

Top module: `vid_ramp`

## Requirements
- R1: After reset the DAC code is 0, and busy and power-good are both low.
- R2: In any one clock cycle the DAC code changes by at most one code. The code stays between 0 and 76 and reaches the accepted target exactly, with no overshoot.
- R3: While rising, consecutive steps are (rise_sel+1) µs apart. The first step after a new target comes within that interval.
- R4: While falling, consecutive steps are (fall_sel+1) µs apart. The first step after a new target comes within that interval.
- R5: A target above 76 is discarded. Any target presented while vid_en is low is discarded. A discarded target does not change the code or busy.
- R6: When a new target arrives during a ramp, the ramp continues from the current code, one code at a time, toward the new target.
- R7: busy is high exactly while the DAC code differs from the accepted target.
- R8: While ss_done is low, power-good is low from the next cycle on.
- R9: With ss_done high and power-good low (and no fault since soft-start), power-good rises in the cycle after above_mid is seen high.
- R10: A below_low condition must hold for the selected delay before power-good falls. dly_sel codes 0, 1, 2 and 3 select 0, 10, 20 and 40 µs. A shorter condition leaves power-good high. With a delay of 0, power-good falls in the next cycle.
- R11: After a fault has dropped power-good, above_mid alone does not raise it again. It rises in the cycle after above_high is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_en | input | 1 | Allows the target input to be accepted |
| target | input | 7 | Requested code, 0..76 |
| rise_sel | input | 3 | Rising step interval minus 1, in µs |
| fall_sel | input | 3 | Falling step interval minus 1, in µs |
| dly_sel | input | 2 | Power-good fault delay: 0, 10, 20 or 40 µs |
| ss_done | input | 1 | Soft-start finished |
| below_low | input | 1 | Output below 87.5 % of nominal |
| above_mid | input | 1 | Output at or above 90 % of nominal |
| above_high | input | 1 | Output above 92.5 % of nominal |
| code | output | 7 | Current DAC code |
| busy | output | 1 | Ramp in progress |
| pg | output | 1 | Power-good |

## Verification
The hardest behaviour to reach is the fault delay boundary. The prescaler runs freely, so its phase relative to an input edge is unknown at the ports. The bench therefore checks fall times against a window one tick wide, and checks steady-state step spacing to the exact cycle. Each delay setting is first given an under-voltage pulse two ticks shorter than the delay, which must leave power-good high. Only then is a sustained fault applied and its fall time measured.

// File: rtl/vid_ramp.sv
module vid_ramp #(
  parameter int CLK_PER_US = 125,
  parameter int CODE_W     = 7,
  parameter int MAX_CODE   = 76,
  parameter int SEL_W      = 3,
  parameter int DLY_UNIT   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vid_en,
  input  logic [CODE_W-1:0] target,
  input  logic [SEL_W-1:0]  rise_sel,
  input  logic [SEL_W-1:0]  fall_sel,
  input  logic [1:0]        dly_sel,
  input  logic              ss_done,
  input  logic              below_low,
  input  logic              above_mid,
  input  logic              above_high,
  output logic [CODE_W-1:0] code,
  output logic              busy,
  output logic              pg
);
  localparam int PS_W  = $clog2(CLK_PER_US + 1);
  localparam int DLY_W = $clog2(4 * DLY_UNIT + 1);

  logic [PS_W-1:0]   ps;
  logic [CODE_W-1:0] tgt;
  logic [SEL_W-1:0]  scnt;
  logic [DLY_W-1:0]  dcnt, dly;
  logic              tick, up, dropped;
  logic [SEL_W-1:0]  ivl;

  assign tick = (ps == PS_W'(CLK_PER_US - 1));
  assign busy = (code != tgt);
  assign up   = (tgt > code);
  assign ivl  = up ? rise_sel : fall_sel;
  assign dly  = (dly_sel == 2'd0) ? '0 : DLY_W'(DLY_UNIT << (dly_sel - 2'd1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    ps <= '0;
    else if (tick) ps <= '0;
    else           ps <= ps + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      tgt <= '0;
    else if (vid_en && target <= CODE_W'(MAX_CODE))
      tgt <= target;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      code <= '0;
      scnt <= '0;
    end else if (!busy) begin
      scnt <= '0;
    end else if (tick) begin
      if (scnt >= ivl) begin
        scnt <= '0;
        code <= up ? code + 1'b1 : code - 1'b1;
      end else begin
        scnt <= scnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pg      <= 1'b0;
      dropped <= 1'b0;
      dcnt    <= '0;
    end else if (!ss_done) begin
      pg      <= 1'b0;
      dropped <= 1'b0;
      dcnt    <= '0;
    end else if (!pg) begin
      dcnt <= '0;
      if (dropped ? above_high : above_mid) pg <= 1'b1;
    end else if (!below_low) begin
      dcnt <= '0;
    end else if (dly == '0 || (tick && dcnt == dly - 1'b1)) begin
      pg      <= 1'b0;
      dropped <= 1'b1;
      dcnt    <= '0;
    end else if (tick) begin
      dcnt <= dcnt + 1'b1;
    end
endmodule

// File: rtl/vid_ramp_chk.sv
module vid_ramp_chk #(
  parameter int CODE_W   = 7,
  parameter int MAX_CODE = 76
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] code,
  input logic              busy,
  input logic              pg,
  input logic              ss_done,
  input logic              below_low,
  input logic              above_mid,
  input logic              above_high
);
  p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (code == $past(code)) || (code == $past(code) + 1'b1) || ($past(code) == code + 1'b1));

  p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    code <= CODE_W'(MAX_CODE));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(code));

  p_ss_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_done |=> !pg);

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg) |-> $past(ss_done && (above_mid || above_high)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pg && !below_low && ss_done) |=> pg);
endmodule

bind vid_ramp vid_ramp_chk #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .code(code), .busy(busy), .pg(pg),
  .ss_done(ss_done), .below_low(below_low), .above_mid(above_mid),
  .above_high(above_high)
);

// File: tb/test_vid_ramp.sv
module test_vid_ramp;
  localparam int P = 125;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, vid_en, ss_done, below_low, above_mid, above_high, busy, pg;
  logic [6:0] target, code;
  logic [2:0] rise_sel, fall_sel;
  logic [1:0] dly_sel;

  int n_chk = 0, n_bad = 0;
  bit jump_seen = 0;
  logic [6:0] prev_code;

  vid_ramp i_vid_ramp (
    .clk(clk), .rst_n(rst_n), .vid_en(vid_en), .target(target),
    .rise_sel(rise_sel), .fall_sel(fall_sel), .dly_sel(dly_sel),
    .ss_done(ss_done), .below_low(below_low), .above_mid(above_mid),
    .above_high(above_high), .code(code), .busy(busy), .pg(pg)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_change(output int n);
    logic [6:0] p;
    p = code;
    n = 0;
    do begin @(negedge clk); n++; end while (code == p && n < 20000);
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    do begin @(negedge clk); n++; end while (busy && n < 30000);
  endtask

  task automatic wait_pg_low(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (pg && n < 10000);
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && prev_code !== 7'bx) begin
      if (code > prev_code + 7'd1 || prev_code > code + 7'd1) jump_seen = 1;
    end
    prev_code = code;
  end

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, s, d, c0;
    rst_n = 0; vid_en = 0; target = 0; rise_sel = 0; fall_sel = 0; dly_sel = 0;
    ss_done = 0; below_low = 0; above_mid = 0; above_high = 0;
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk(code == 0, "R1 code", code, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(pg == 0, "R1 pg", pg, 0);

    vid_en = 1;
    for (s = 0; s < 8; s++) begin
      rise_sel = 3'(s);
      c0 = code;
      target = 7'(c0 + 3);
      wait_change(n);
      chk(n >= s * P + 1 && n <= (s + 1) * P, "R3 first rise", n, (s + 1) * P);
      for (int k = 0; k < 2; k++) begin
        wait_change(n);
        chk(n == (s + 1) * P, "R3 rise interval", n, (s + 1) * P);
      end
      cyc(1);
      chk(code == c0 + 3 && busy == 0, "R7 idle at target", code, c0 + 3);
    end

    rise_sel = 0;
    for (s = 0; s < 8; s++) begin
      fall_sel = 3'(s);
      c0 = code;
      target = 7'(c0 - 2);
      wait_change(n);
      chk(n >= s * P + 1 && n <= (s + 1) * P, "R4 first fall", n, (s + 1) * P);
      wait_change(n);
      chk(n == (s + 1) * P, "R4 fall interval", n, (s + 1) * P);
      cyc(1);
      chk(code == c0 - 2 && busy == 0, "R7 idle at target", code, c0 - 2);
    end

    fall_sel = 0;
    target = 76;
    cyc(2);
    chk(busy == 1, "R7 busy during ramp", busy, 1);
    wait_idle();
    chk(code == 76, "R2 top of range", code, 76);
    target = 0;
    wait_idle();
    chk(code == 0, "R2 bottom of range", code, 0);

    target = 100;
    cyc(500);
    chk(code == 0 && busy == 0, "R5 illegal target", code, 0);
    vid_en = 0;
    target = 5;
    cyc(500);
    chk(code == 0 && busy == 0, "R5 disabled target", code, 0);
    vid_en = 1;
    wait_idle();
    chk(code == 5, "R5 accepted after enable", code, 5);

    target = 40;
    while (code != 20) @(negedge clk);
    target = 10;
    wait_change(n);
    chk(code == 19, "R6 retarget continues from current", code, 19);
    wait_idle();
    chk(code == 10, "R6 reaches new target", code, 10);
    chk(jump_seen == 0, "R2 no jump", jump_seen, 0);

    above_mid = 1;
    cyc(10);
    chk(pg == 0, "R8 pg held during soft-start", pg, 0);
    above_mid = 0;
    ss_done = 1;
    cyc(5);
    chk(pg == 0, "R9 no release below 90pct", pg, 0);
    above_mid = 1;
    cyc(1);
    chk(pg == 1, "R9 release at 90pct", pg, 1);

    dly_sel = 0;
    below_low = 1;
    wait_pg_low(n);
    chk(n == 1, "R10 zero delay", n, 1);
    below_low = 0;
    cyc(20);
    chk(pg == 0, "R11 90pct not enough after fault", pg, 0);
    above_high = 1;
    cyc(1);
    chk(pg == 1, "R11 release at 92.5pct", pg, 1);

    for (s = 1; s < 4; s++) begin
      dly_sel = 2'(s);
      d = 10 << (s - 1);
      below_low = 1;
      cyc((d - 2) * P);
      chk(pg == 1, "R10 short fault ignored", pg, 1);
      below_low = 0;
      cyc(2);
      below_low = 1;
      wait_pg_low(n);
      chk(n >= (d - 1) * P + 1 && n <= d * P, "R10 fault delay", n, d * P);
      below_low = 0;
      cyc(1);
      chk(pg == 1, "R11 recovery with 92.5pct", pg, 1);
    end

    ss_done = 0;
    cyc(1);
    chk(pg == 0, "R8 pg drops with soft-start", pg, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule